// File: doc/BRIEF.md
# Fifty-Pin General-Purpose I/O Register Bank

This block is a memory-mapped general-purpose I/O port with fifty pins. Software reaches it over a simple 16-bit register bus with an enable, a write strobe, a 9-bit byte offset and separate write and read data. Pins are grouped into 16-bit words. Pins 0 to 31 each have a direction bit and an output latch. Reading their data word returns the driven value for outputs and the synchronised pad level for inputs. Pins 32 to 47 are output-only. Pins 48 and 49 have no direction word. Their output enables are kept next to their data bits in the top data word.

The bank also drives the control signals for pull resistors on pins 0 to 14. For each of those pins it gives a pull-up enable and a pull-down enable, and at most one of the two is active. The pad cells and the resistors themselves are outside the block. The external reset is asserted asynchronously and leaves reset synchronously to the clock through a two-stage reset synchroniser inside the block.

Top module: `pio_bank`

## Requirements
- R1: After reset every register bit is zero. pin_oe is zero on pins 0–31 and 48–49, and is one on the output-only pins 32–47. pin_out, pull_up_en and pull_dn_en are all zero.
- R2: Direction words sit at offset 0x000 (pins 0–15) and 0x002 (pins 16–31). Bit i set makes pin base+i an output (pin_oe high). A read returns the stored word.
- R3: Data words sit at 0x004 (pins 0–15) and 0x006 (pins 16–31). A write loads the output latch, which appears on pin_out. A read returns the latch bit for each output pin and the synchronised pin_in level for each input pin, at bit position pin minus base pin.
- R4: An input level shows in the data-word read after two rising clock edges, not after one.
- R5: The word at 0x01C is the output latch for pins 32–47. Those pins are always driven, and a read returns the latch.
- R6: In the word at 0x01E, bits 1:0 are the output data of pins 49:48 and bits 9:8 are their output enables. All other bits read zero and ignore writes.
- R7: The word at 0x1E0 holds the pull enables and the word at 0x1E2 holds the pull selects (1 = up, 0 = down) for pins 0–14. Bit 15 of both words reads zero. pull_up_en = enable AND select, and pull_dn_en = enable AND NOT select.
- R8: A cleared enable bit holds both pull outputs of its pin low, whatever its select bit holds, and the select bit keeps its value.
- R9: A read from an offset that is not mapped (including odd offsets) returns zero. A write to such an offset changes no register and no output.
- R10: A write takes effect on the rising edge that samples it. Outputs keep their old value before that edge. bus_rdata is zero while bus_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| pin_in | input | 32 | Pad levels of pins 0–31 |
| pin_out | output | 50 | Output data for all pins |
| pin_oe | output | 50 | Output enable for all pins |
| pull_up_en | output | 15 | Pull-up enable for pins 0–14 |
| pull_dn_en | output | 15 | Pull-down enable for pins 0–14 |

## Verification
The hardest case to reach from the ports is the two-stage delay on input readback. A read only shows the level once the pin is an input, and the level has to change between two known edges. The bench first clears the direction word and holds the read address on the bus. It then changes pin_in at a falling edge and samples bus_rdata at the next two falling edges: the first must still show the old level, the second the new one. The mixed-direction read is also covered: a word with half its pins as outputs must merge latch bits and input bits one by one.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned OFS_W     = 9;
  localparam int unsigned PULL_PINS = 15;
  localparam int unsigned TOP_PINS  = 2;
  localparam int unsigned TOP_OE_LSB = 8;

  localparam logic [OFS_W-1:0] OFS_DIR_LO   = 9'h000;
  localparam logic [OFS_W-1:0] OFS_DIR_HI   = 9'h002;
  localparam logic [OFS_W-1:0] OFS_DAT_LO   = 9'h004;
  localparam logic [OFS_W-1:0] OFS_DAT_HI   = 9'h006;
  localparam logic [OFS_W-1:0] OFS_OUT_MID  = 9'h01C;
  localparam logic [OFS_W-1:0] OFS_OUT_TOP  = 9'h01E;
  localparam logic [OFS_W-1:0] OFS_PULL_EN  = 9'h1E0;
  localparam logic [OFS_W-1:0] OFS_PULL_SEL = 9'h1E2;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_DIR_LO,
    RS_DIR_HI,
    RS_DAT_LO,
    RS_DAT_HI,
    RS_OUT_MID,
    RS_OUT_TOP,
    RS_PULL_EN,
    RS_PULL_SEL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_DIR_LO:   return RS_DIR_LO;
      OFS_DIR_HI:   return RS_DIR_HI;
      OFS_DAT_LO:   return RS_DAT_LO;
      OFS_DAT_HI:   return RS_DAT_HI;
      OFS_OUT_MID:  return RS_OUT_MID;
      OFS_OUT_TOP:  return RS_OUT_TOP;
      OFS_PULL_EN:  return RS_PULL_EN;
      OFS_PULL_SEL: return RS_PULL_SEL;
      default:      return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end

  assign q = stable_q;

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned NPULL = PULL_PINS,
  parameter int unsigned NTOP  = TOP_PINS,
  parameter int unsigned OE_LSB = TOP_OE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DW-1:0]     wdata,
  output logic [2*DW-1:0]   dir_q,
  output logic [2*DW-1:0]   dat_q,
  output logic [DW-1:0]     mid_q,
  output logic [NTOP-1:0]   top_dat_q,
  output logic [NTOP-1:0]   top_oe_q,
  output logic [NPULL-1:0]  pen_q,
  output logic [NPULL-1:0]  psel_q
);

  logic [2*DW-1:0]  dir_d;
  logic [2*DW-1:0]  dat_d;
  logic [DW-1:0]    mid_d;
  logic [NTOP-1:0]  top_dat_d;
  logic [NTOP-1:0]  top_oe_d;
  logic [NPULL-1:0] pen_d;
  logic [NPULL-1:0] psel_d;

  // Next-state: each register holds unless its own word is written.
  always_comb begin
    dir_d     = dir_q;
    dat_d     = dat_q;
    mid_d     = mid_q;
    top_dat_d = top_dat_q;
    top_oe_d  = top_oe_q;
    pen_d     = pen_q;
    psel_d    = psel_q;
    if (wr_en) begin
      case (sel)
        RS_DIR_LO:   dir_d[DW-1:0]    = wdata;
        RS_DIR_HI:   dir_d[2*DW-1:DW] = wdata;
        RS_DAT_LO:   dat_d[DW-1:0]    = wdata;
        RS_DAT_HI:   dat_d[2*DW-1:DW] = wdata;
        RS_OUT_MID:  mid_d            = wdata;
        RS_OUT_TOP: begin
          top_dat_d = wdata[NTOP-1:0];
          top_oe_d  = wdata[OE_LSB +: NTOP];
        end
        RS_PULL_EN:  pen_d            = wdata[NPULL-1:0];
        RS_PULL_SEL: psel_d           = wdata[NPULL-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      dat_q     <= '0;
      mid_q     <= '0;
      top_dat_q <= '0;
      top_oe_q  <= '0;
      pen_q     <= '0;
      psel_q    <= '0;
    end else begin
      dir_q     <= dir_d;
      dat_q     <= dat_d;
      mid_q     <= mid_d;
      top_dat_q <= top_dat_d;
      top_oe_q  <= top_oe_d;
      pen_q     <= pen_d;
      psel_q    <= psel_d;
    end
  end

  // R2: a write to the low direction word appears at the next edge
  a_r2_dir_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_DIR_LO) |=> (dir_q[DW-1:0] == $past(wdata)));

  // R6: top-pin enables come from the upper field of the top data word
  a_r6_top_oe_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_OUT_TOP) |=> (top_oe_q == $past(wdata[OE_LSB +: NTOP])));

  // R7: pull enable word keeps only the pull-capable bits
  a_r7_pull_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_PULL_EN) |=> (pen_q == $past(wdata[NPULL-1:0])));

  // R9: writes to unmapped offsets leave every register untouched
  a_r9_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_NONE) |=>
      $stable({dir_q, dat_q, mid_q, top_dat_q, top_oe_q, pen_q, psel_q}));

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned AW    = OFS_W,
  parameter int unsigned NPULL = PULL_PINS,
  parameter int unsigned NTOP  = TOP_PINS,
  localparam int unsigned NIO   = 2 * DW,
  localparam int unsigned NPINS = NIO + DW + NTOP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NIO-1:0]    pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPULL-1:0]  pull_up_en,
  output logic [NPULL-1:0]  pull_dn_en
);

  logic             rst_core_n;
  reg_sel_e         sel;
  logic             wr_en;
  logic [NIO-1:0]   dir_q;
  logic [NIO-1:0]   dat_q;
  logic [DW-1:0]    mid_q;
  logic [NTOP-1:0]  top_dat_q;
  logic [NTOP-1:0]  top_oe_q;
  logic [NPULL-1:0] pen_q;
  logic [NPULL-1:0] psel_q;
  logic [NIO-1:0]   lvl_q;
  logic [NIO-1:0]   io_view;
  logic [DW-1:0]    rd_mux;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_core_n)
  );

  pio_sync2 #(.WIDTH(NIO)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d    (pin_in),
    .q    (lvl_q)
  );

  assign sel   = decode_ofs(bus_addr);
  assign wr_en = bus_en & bus_we;

  pio_regs #(
    .DW    (DW),
    .NPULL (NPULL),
    .NTOP  (NTOP),
    .OE_LSB(TOP_OE_LSB)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .dat_q    (dat_q),
    .mid_q    (mid_q),
    .top_dat_q(top_dat_q),
    .top_oe_q (top_oe_q),
    .pen_q    (pen_q),
    .psel_q   (psel_q)
  );

  // Per-pin readback: the driven value for outputs, the synchronised level for inputs.
  for (genvar p = 0; p < NIO; p++) begin : g_view
    assign io_view[p] = dir_q[p] ? dat_q[p] : lvl_q[p];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      RS_DIR_LO:   rd_mux = dir_q[DW-1:0];
      RS_DIR_HI:   rd_mux = dir_q[NIO-1:DW];
      RS_DAT_LO:   rd_mux = io_view[DW-1:0];
      RS_DAT_HI:   rd_mux = io_view[NIO-1:DW];
      RS_OUT_MID:  rd_mux = mid_q;
      RS_OUT_TOP: begin
        rd_mux[NTOP-1:0]              = top_dat_q;
        rd_mux[TOP_OE_LSB +: NTOP]    = top_oe_q;
      end
      RS_PULL_EN:  rd_mux[NPULL-1:0] = pen_q;
      RS_PULL_SEL: rd_mux[NPULL-1:0] = psel_q;
      default:     rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_en ? rd_mux : '0;

  assign pin_out = {top_dat_q, mid_q, dat_q};
  assign pin_oe  = {top_oe_q, {DW{1'b1}}, dir_q};

  for (genvar k = 0; k < NPULL; k++) begin : g_pull
    assign pull_up_en[k] = pen_q[k] &  psel_q[k];
    assign pull_dn_en[k] = pen_q[k] & ~psel_q[k];
  end

  // R7: a write to the select word reaches the pull outputs at the next edge
  a_r7_pull_sel_effect: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && sel == RS_PULL_SEL) |=>
      (pull_up_en == (pen_q & $past(bus_wdata[NPULL-1:0]))));

endmodule

// File: tb/pio_bank_test.sv
module pio_bank_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [8:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in;
  logic [49:0] pin_out;
  logic [49:0] pin_oe;
  logic [14:0] pull_up_en;
  logic [14:0] pull_dn_en;

  int checks;
  int failures;
  bit done;

  pio_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pull_up_en(pull_up_en),
    .pull_dn_en(pull_dn_en)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    check("R1 pin_oe", 64'(pin_oe), 64'({2'b00, 16'hFFFF, 32'h0}));
    check("R1 pin_out", 64'(pin_out), 64'h0);
    check("R1 pull_up_en", 64'(pull_up_en), 64'h0);
    check("R1 pull_dn_en", 64'(pull_dn_en), 64'h0);
    bus_read(9'h000, r); check("R1 dir_lo", 64'(r), 64'h0);
    bus_read(9'h01E, r); check("R1 out_top", 64'(r), 64'h0);
    bus_read(9'h1E2, r); check("R1 pull_sel", 64'(r), 64'h0);
    check("R10 rdata idle", 64'(bus_rdata), 64'h0);
  endtask

  task automatic t_direction();
    logic [15:0] r;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 9'h000; bus_wdata = 16'hA5A5;
    #1 check("R10 oe before edge", 64'(pin_oe[15:0]), 64'h0);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    check("R10 R2 oe after edge", 64'(pin_oe[15:0]), 64'hA5A5);
    bus_write(9'h002, 16'h0F0F);
    check("R2 oe hi", 64'(pin_oe[31:16]), 64'h0F0F);
    bus_read(9'h002, r); check("R2 dir_hi read", 64'(r), 64'h0F0F);
  endtask

  task automatic t_data_mix();
    logic [15:0] r;
    bus_write(9'h000, 16'h00FF);
    pin_in[15:0] = 16'hABCD;
    bus_write(9'h004, 16'h1234);
    check("R3 pin_out lo", 64'(pin_out[15:0]), 64'h1234);
    repeat (2) @(negedge clk);
    bus_read(9'h004, r); check("R3 mixed read", 64'(r), 64'hAB34);
    bus_write(9'h006, 16'hC3C3);
    check("R3 pin_out hi", 64'(pin_out[31:16]), 64'hC3C3);
  endtask

  task automatic t_sync_delay();
    bus_write(9'h002, 16'h0000);
    pin_in[31:16] = 16'h0000;
    repeat (3) @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 9'h006;
    pin_in[31:16] = 16'h5A5A;
    @(negedge clk);
    check("R4 one edge old", 64'(bus_rdata), 64'h0000);
    @(negedge clk);
    check("R4 two edges new", 64'(bus_rdata), 64'h5A5A);
    bus_en = 1'b0;
  endtask

  task automatic t_mid();
    logic [15:0] r;
    bus_write(9'h01C, 16'hBEEF);
    check("R5 pin_out mid", 64'(pin_out[47:32]), 64'hBEEF);
    check("R5 oe mid", 64'(pin_oe[47:32]), 64'hFFFF);
    bus_read(9'h01C, r); check("R5 mid read", 64'(r), 64'hBEEF);
  endtask

  task automatic t_top();
    logic [15:0] r;
    bus_write(9'h01E, 16'hFFFF);
    bus_read(9'h01E, r); check("R6 top read masked", 64'(r), 64'h0303);
    check("R6 top oe", 64'(pin_oe[49:48]), 64'h3);
    bus_write(9'h01E, 16'h0201);
    check("R6 top oe split", 64'(pin_oe[49:48]), 64'h2);
    check("R6 top out split", 64'(pin_out[49:48]), 64'h1);
  endtask

  task automatic t_pull();
    logic [15:0] r;
    bus_write(9'h1E0, 16'hFFFF);
    bus_read(9'h1E0, r); check("R7 enable read", 64'(r), 64'h7FFF);
    bus_write(9'h1E2, 16'h80F0);
    bus_read(9'h1E2, r); check("R7 select read", 64'(r), 64'h00F0);
    check("R7 pull up", 64'(pull_up_en), 64'h00F0);
    check("R7 pull down", 64'(pull_dn_en), 64'h7F0F);
    bus_write(9'h1E0, 16'h0000);
    check("R8 up off", 64'(pull_up_en), 64'h0);
    check("R8 down off", 64'(pull_dn_en), 64'h0);
    bus_read(9'h1E2, r); check("R8 select kept", 64'(r), 64'h00F0);
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    logic [49:0] out_before, oe_before;
    out_before = pin_out;
    oe_before  = pin_oe;
    bus_write(9'h008, 16'hFFFF);
    bus_write(9'h003, 16'hFFFF);
    bus_write(9'h1E4, 16'hFFFF);
    bus_read(9'h008, r); check("R9 read gap", 64'(r), 64'h0);
    bus_read(9'h003, r); check("R9 read odd", 64'(r), 64'h0);
    check("R9 pin_out held", 64'(pin_out), 64'(out_before));
    check("R9 pin_oe held", 64'(pin_oe), 64'(oe_before));
    check("R9 pulls held", 64'({pull_up_en, pull_dn_en}), 64'h0);
    bus_read(9'h1E2, r); check("R9 select held", 64'(r), 64'h00F0);
    bus_read(9'h01C, r); check("R9 mid held", 64'(r), 64'hBEEF);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direction();
    t_data_mix();
    t_sync_delay();
    t_mid();
    t_top();
    t_pull();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule